// File: doc/BRIEF.md
# In-Order Writeback Arbitration Queue

This block sits at the writeback stage of a single-issue pipeline. The issue logic dispatches at most one instruction per cycle, to one of several parallel execution units. Each time it does, it pushes that unit's identifier into a first-in first-out record. Only the unit named at the head of that record may write the register file. The write grant, the result and the destination register index are driven combinationally in the cycle in which the head unit signals ready.

A unit that signals ready while it is not at the head is stalled. It keeps its result and may not take new work until its turn comes. When the record is full and the head cannot retire, the whole pipeline is stalled, issue included. A flush input empties the record in one cycle. A ready seen while the record is empty is a protocol violation and sets a sticky error flag.

Top module: `wb_order_arbiter`

## Requirements
- R1: A synchronous reset (`rst_n` low at a clock edge) empties the record and clears the error flag. Afterwards `unit_stall`, `pipe_stall` and `rf_we` are all low while no unit is ready.
- R2: Register-file writes are granted in exactly the order in which unit identifiers were accepted on the push port.
- R3: `rf_we` is high in the cycle in which the head unit's `unit_ready` bit is high, and no flush is requested. In that cycle, `rf_wdata` equals the head unit's slice `unit_result[u*DATA_W +: DATA_W]` and `rf_waddr` equals `unit_rd[u*REG_W +: REG_W]`.
- R4: `unit_stall[i]` is high in every cycle in which `unit_ready[i]` is high, unit i is not the head entry, and no flush is requested. It is low otherwise.
- R5: Once the head retires, the next recorded entry becomes the head, and its unit's ready produces the next write.
- R6: `pipe_stall` is high when the record holds DEPTH entries, the head is not retiring and no flush is requested. A push offered in that cycle is dropped.
- R7: A push and a retire in the same cycle leave the occupancy unchanged. A push into a full record is accepted when the head retires in that cycle.
- R8: While the record is empty, no write occurs. Any unit ready in that state (without flush) sets `proto_err` from the next cycle on, and it stays set until reset.
- R9: A `flush` cycle grants no write, drives all unit stalls and `pipe_stall` low, drops any push and leaves the record empty from the next cycle.
- R10: At most one register-file write occurs per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Empty the record and release stalls |
| push_valid | input | 1 | Issue logic dispatched an instruction this cycle |
| push_unit | input | UID_W | Identifier of the unit that received it |
| unit_ready | input | NUM_UNITS | Per-unit result-ready flags |
| unit_result | input | NUM_UNITS*DATA_W | Per-unit results, unit i at slice i |
| unit_rd | input | NUM_UNITS*REG_W | Per-unit destination register indexes |
| unit_stall | output | NUM_UNITS | Per-unit hold for out-of-order ready |
| rf_we | output | 1 | Register-file write grant |
| rf_wdata | output | DATA_W | Result of the granted unit |
| rf_waddr | output | REG_W | Destination index of the granted unit |
| pipe_stall | output | 1 | Global stall when the record is full and blocked |
| proto_err | output | 1 | Sticky flag for ready while empty |

## Verification
A corrupted head pointer or identifier store shows up at the first retire. The write goes to the wrong unit's result, or `unit_stall` marks the true head, visible in the same cycle the units signal ready. A wrong occupancy count shows up as `pipe_stall` asserting one push too early or too late, or as a push into a full record that is accepted or dropped in the wrong cycle. The next drain then reveals the lost or duplicated entry. A missing error latch is visible one cycle after the first ready to an empty record.

// File: rtl/wbq_pkg.sv
// Package: shared helpers for the writeback ordering queue.
// Assumes pointer values stay below the depth passed in.
package wbq_pkg;
    // Next circular pointer value for a store of the given depth.
    function automatic int unsigned ptr_next(input int unsigned ptr, input int unsigned depth);
        return (ptr == depth - 1) ? 0 : ptr + 1;
    endfunction
endpackage

// File: rtl/wbq_id_fifo.sv
// Module: circular store of unit identifiers in issue order.
// Assumes push is only raised when space exists or a pop happens in the
// same cycle; flush wins over push and pop.
module wbq_id_fifo #(
    parameter int DEPTH = 4,
    parameter int ID_W  = 2,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic             pop,
    input  logic [ID_W-1:0]  push_id,
    output logic [ID_W-1:0]  head_id,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full
);
    import wbq_pkg::*;

    logic [ID_W-1:0]  slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    // Status and head output derived from pointers and count.
    always_comb begin
        empty   = (count == '0);
        full    = (count == CNT_W'(DEPTH));
        head_id = slots[rd_ptr];
    end

    // Pointer and occupancy update; flush and reset empty the store.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= PTR_W'(ptr_next(int'(wr_ptr), DEPTH));
            if (pop)  rd_ptr <= PTR_W'(ptr_next(int'(rd_ptr), DEPTH));
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    // Identifier storage; contents need no reset.
    always_ff @(posedge clk) begin
        if (rst_n && !flush && push) slots[wr_ptr] <= push_id;
    end
endmodule

// File: rtl/wbq_result_mux.sv
// Module: selects one unit's result and destination index.
// Assumes sel is below NUM_UNITS whenever the output is used.
module wbq_result_mux #(
    parameter int NUM_UNITS = 4,
    parameter int DATA_W    = 32,
    parameter int REG_W     = 5,
    parameter int UID_W     = 2
) (
    input  logic [UID_W-1:0]            sel,
    input  logic [NUM_UNITS*DATA_W-1:0] results,
    input  logic [NUM_UNITS*REG_W-1:0]  dests,
    output logic [DATA_W-1:0]           data,
    output logic [REG_W-1:0]            addr
);
    logic [DATA_W-1:0] res_arr [NUM_UNITS];
    logic [REG_W-1:0]  dst_arr [NUM_UNITS];

    // Unpack the flat buses into per-unit slices.
    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unpack
        assign res_arr[g] = results[g*DATA_W +: DATA_W];
        assign dst_arr[g] = dests[g*REG_W +: REG_W];
    end

    // Pick the slice of the selected unit.
    always_comb begin
        data = '0;
        addr = '0;
        for (int i = 0; i < NUM_UNITS; i++) begin
            if (sel == UID_W'(i)) begin
                data = res_arr[i];
                addr = dst_arr[i];
            end
        end
    end
endmodule

// File: rtl/wbq_stall_gen.sv
// Module: per-unit hold for units whose ready arrives out of order.
// Assumes head_valid is low when the record is empty.
module wbq_stall_gen #(
    parameter int NUM_UNITS = 4,
    parameter int UID_W     = 2
) (
    input  logic                 flush,
    input  logic                 head_valid,
    input  logic [UID_W-1:0]     head_id,
    input  logic [NUM_UNITS-1:0] unit_ready,
    output logic [NUM_UNITS-1:0] unit_stall
);
    // One hold per unit: ready while not head, released by flush.
    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_stall
        assign unit_stall[g] = unit_ready[g] && !flush &&
                               !(head_valid && (head_id == UID_W'(g)));
    end
endmodule

// File: rtl/wb_order_arbiter.sv
// Module: top of the in-order writeback arbiter. It records issue order,
// grants register-file writes only to the head unit, stalls out-of-order
// units and the whole pipe when full, and latches protocol errors.
// Assumes the issue logic honours pipe_stall and units hold ready while stalled.
module wb_order_arbiter #(
    parameter int NUM_UNITS = 4,
    parameter int DEPTH     = 4,
    parameter int DATA_W    = 32,
    parameter int REG_W     = 5,
    localparam int UID_W = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush,
    input  logic                        push_valid,
    input  logic [UID_W-1:0]            push_unit,
    input  logic [NUM_UNITS-1:0]        unit_ready,
    input  logic [NUM_UNITS*DATA_W-1:0] unit_result,
    input  logic [NUM_UNITS*REG_W-1:0]  unit_rd,
    output logic [NUM_UNITS-1:0]        unit_stall,
    output logic                        rf_we,
    output logic [DATA_W-1:0]           rf_wdata,
    output logic [REG_W-1:0]            rf_waddr,
    output logic                        pipe_stall,
    output logic                        proto_err
);
    logic [UID_W-1:0] head_id;
    logic [CNT_W-1:0] occ;
    logic             q_empty, q_full;
    logic             head_ready, do_pop, do_push;

    // Retire and accept decisions for this cycle.
    always_comb begin
        head_ready = !q_empty && unit_ready[head_id];
        do_pop     = head_ready && !flush;
        do_push    = push_valid && !flush && (!q_full || do_pop);
        rf_we      = do_pop;
        pipe_stall = q_full && !do_pop && !flush;
    end

    wbq_id_fifo #(.DEPTH(DEPTH), .ID_W(UID_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(do_push), .pop(do_pop), .push_id(push_unit),
        .head_id(head_id), .count(occ), .empty(q_empty), .full(q_full)
    );

    wbq_result_mux #(.NUM_UNITS(NUM_UNITS), .DATA_W(DATA_W), .REG_W(REG_W), .UID_W(UID_W)) u_mux (
        .sel(head_id), .results(unit_result), .dests(unit_rd),
        .data(rf_wdata), .addr(rf_waddr)
    );

    wbq_stall_gen #(.NUM_UNITS(NUM_UNITS), .UID_W(UID_W)) u_stall (
        .flush(flush), .head_valid(!q_empty), .head_id(head_id),
        .unit_ready(unit_ready), .unit_stall(unit_stall)
    );

    // Sticky protocol error: ready seen while nothing is recorded.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    proto_err <= 1'b0;
        else if (q_empty && (|unit_ready) && !flush)   proto_err <= 1'b1;
    end
endmodule

// File: rtl/wbq_checker.sv
// Module: property checker for the writeback arbiter, bound to the top.
// Assumes occ is the record occupancy inside the top module.
module wbq_checker #(
    parameter int NUM_UNITS = 4,
    parameter int DEPTH     = 4,
    parameter int CNT_W     = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 flush,
    input logic [NUM_UNITS-1:0] unit_ready,
    input logic [NUM_UNITS-1:0] unit_stall,
    input logic                 rf_we,
    input logic                 pipe_stall,
    input logic                 proto_err,
    input logic [CNT_W-1:0]     occ
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH)); // R6
    AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == CNT_W'(DEPTH) && !rf_we && !flush) |-> pipe_stall); // R6
    AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> ($countones(unit_ready & ~unit_stall) == 1)); // R10
    AST_EMPTY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0) |-> !rf_we); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err); // R8
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (occ == '0)); // R9
    AST_FLUSH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (unit_stall == '0 && !rf_we && !pipe_stall)); // R9
endmodule

bind wb_order_arbiter wbq_checker #(.NUM_UNITS(NUM_UNITS), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .unit_ready(unit_ready),
    .unit_stall(unit_stall), .rf_we(rf_we), .pipe_stall(pipe_stall),
    .proto_err(proto_err), .occ(occ)
);

// File: tb/tb_wb_order_arbiter.sv
// Bench: scoreboard for the writeback arbiter. The driver records expected
// grants in issue order; the monitor pops them as writes appear.
module tb_wb_order_arbiter;
    localparam int NU = 4, DEPTH = 4, DW = 32, RW = 5, UW = 2;

    logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, push_valid = 1'b0;
    logic [UW-1:0] push_unit = '0;
    logic [NU-1:0] unit_ready = '0;
    logic [NU*DW-1:0] unit_result;
    logic [NU*RW-1:0] unit_rd;
    logic [NU-1:0] unit_stall;
    logic rf_we, pipe_stall, proto_err;
    logic [DW-1:0] rf_wdata;
    logic [RW-1:0] rf_waddr;

    int checks = 0, errors = 0;
    int exp_q[$];
    logic err_m = 1'b0;

    always #2.5 clk = ~clk; // 200 MHz

    wb_order_arbiter #(.NUM_UNITS(NU), .DEPTH(DEPTH), .DATA_W(DW), .REG_W(RW)) dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push_valid(push_valid),
        .push_unit(push_unit), .unit_ready(unit_ready), .unit_result(unit_result),
        .unit_rd(unit_rd), .unit_stall(unit_stall), .rf_we(rf_we),
        .rf_wdata(rf_wdata), .rf_waddr(rf_waddr), .pipe_stall(pipe_stall),
        .proto_err(proto_err)
    );

    function automatic logic [DW-1:0] res_of(input int u);
        return 32'hCAFE_0000 + 32'(u * 17);
    endfunction
    function automatic logic [RW-1:0] rd_of(input int u);
        return RW'(u * 7 + 1);
    endfunction

    initial begin
        for (int u = 0; u < NU; u++) begin
            unit_result[u*DW +: DW] = res_of(u);
            unit_rd[u*RW +: RW]     = rd_of(u);
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: pops the oldest expected grant whenever a write appears (R2, R5).
    always @(negedge clk) begin
        if (rst_n && rf_we) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 write with empty record", 64'(rf_we), 64'd0);
            end else begin
                int u;
                u = exp_q.pop_front();
                check(rf_wdata == res_of(u), "R2/R5 order data", 64'(rf_wdata), 64'(res_of(u)));
                check(rf_waddr == rd_of(u), "R3 dest index", 64'(rf_waddr), 64'(rd_of(u)));
            end
        end
    end

    // Driver: one cycle of stimulus with expectations computed from the model.
    task automatic cycle(input logic pv, input int pu, input logic [NU-1:0] rdy, input logic fl);
        logic [NU-1:0] hmask;
        logic exp_pop, acc, exp_pst, err_next;
        logic [NU-1:0] exp_stall;
        push_valid = pv; push_unit = UW'(pu); unit_ready = rdy; flush = fl;
        hmask = '0;
        if (exp_q.size() > 0) hmask[exp_q[0]] = 1'b1;
        exp_pop   = !fl && (exp_q.size() > 0) && (|(rdy & hmask));
        acc       = pv && !fl && (exp_q.size() < DEPTH || exp_pop);
        exp_pst   = !fl && (exp_q.size() == DEPTH) && !exp_pop;
        exp_stall = fl ? '0 : (rdy & ~hmask);
        err_next  = err_m || (!fl && exp_q.size() == 0 && (|rdy));
        @(negedge clk); #1;
        check(rf_we == exp_pop, "R3/R10 grant", 64'(rf_we), 64'(exp_pop));
        check(unit_stall == exp_stall, "R4 unit stall", 64'(unit_stall), 64'(exp_stall));
        check(pipe_stall == exp_pst, "R6 pipe stall", 64'(pipe_stall), 64'(exp_pst));
        check(proto_err == err_m, "R8 error flag", 64'(proto_err), 64'(err_m));
        if (fl) exp_q.delete();
        if (acc) exp_q.push_back(pu);
        err_m = err_next;
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        // R1: state after reset
        check(!rf_we && unit_stall == '0 && !pipe_stall, "R1 outputs idle", {61'd0, rf_we, pipe_stall, |unit_stall}, 64'd0);
        check(!proto_err, "R1 error clear", 64'(proto_err), 64'd0);
        @(posedge clk); #1;

        // Out-of-order readies are held until the head retires (R2, R4, R5)
        cycle(1, 2, 4'b0000, 0);
        cycle(1, 0, 4'b0000, 0);
        cycle(1, 3, 4'b0000, 0);
        cycle(0, 0, 4'b1001, 0);
        cycle(0, 0, 4'b1101, 0);
        cycle(0, 0, 4'b1001, 0);
        cycle(0, 0, 4'b1000, 0);

        // Fill to depth, blocked push dropped (R6), push into full on retire (R7)
        cycle(1, 1, 4'b0000, 0);
        cycle(1, 1, 4'b0000, 0);
        cycle(1, 2, 4'b0000, 0);
        cycle(1, 3, 4'b0000, 0);
        cycle(1, 0, 4'b0100, 0);
        cycle(1, 0, 4'b0010, 0);
        cycle(0, 0, 4'b0010, 0);
        cycle(1, 1, 4'b0100, 0); // R7 push and retire, occupancy unchanged
        cycle(0, 0, 4'b1111, 0);
        cycle(0, 0, 4'b0001, 0);
        cycle(0, 0, 4'b0010, 0);

        // Flush with the head ready: no write, stalls released, record emptied (R9)
        cycle(1, 1, 4'b0000, 0);
        cycle(1, 2, 4'b0000, 0);
        cycle(1, 0, 4'b0110, 1);
        cycle(1, 3, 4'b0000, 0);
        cycle(0, 0, 4'b1000, 0);

        // Ready while empty sets the sticky error (R8)
        cycle(0, 0, 4'b0100, 0);
        cycle(0, 0, 4'b0000, 0);
        cycle(1, 2, 4'b0000, 0);
        cycle(0, 0, 4'b0100, 0);
        cycle(0, 0, 4'b0000, 0);

        // Reset clears the error and the record (R1)
        rst_n = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        exp_q.delete();
        err_m = 1'b0;
        cycle(0, 0, 4'b0000, 0);
        cycle(1, 3, 4'b0000, 0);
        cycle(0, 0, 4'b1000, 0);
        cycle(0, 0, 4'b0000, 0);
        check(exp_q.size() == 0, "R2 all grants seen", 64'(exp_q.size()), 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule